// File: doc/BRIEF.md
# Multiprocessor Interrupt Router

This block gathers level-sensitive interrupt lines from the rest of the chip and delivers them to a small group of processor cores. Each core has its own interrupt output and its own register window. All cores share one global window. Software turns a source on or off by writing that source's index to a set register or a clear register, so no read-modify-write is needed. A core asks which line to service by reading its acknowledge register. That read returns the lowest-numbered line that can currently reach that core.

The low source indices are private lines. They are gated by a per-core mask and ignore routing. The higher indices are shared lines, and each one is steered by a routing register with one bit per core. Index 0 is not taken from the source inputs: it stands for a per-core doorbell-pending input, which is gated by mask bit 0 of that core. Pending state lives at the device, so an acknowledge read changes nothing. The register port is a plain synchronous read/write port, and read data appears one clock after the read strobe.

Top module: `mpic_router`

## Requirements
- R1: After reset every global enable is 0, every per-core mask bit is 1, every routing register reads 0, every `irq_o` bit is low, and every acknowledge read returns 1023.
- R2: In the global window (`bus_local`=0), a write to offset 0x30 sets the enable of the source whose index is in `bus_wdata[9:0]`, and a write to offset 0x34 clears it. An index of NUM_SRC or above changes nothing.
- R3: In the window of core `bus_cpu`, a write to offset 0x48 sets that core's mask bit for index `bus_wdata[9:0]`, and a write to offset 0x4C clears it. This applies only to indices 0..PRIV_MAX, and it leaves the other cores' masks untouched.
- R4: The global offset 0x100+4*n is the routing register of source n. Bit c selects core c. It reads back what was written in bits [NUM_CPU-1:0], and all of its other bits read 0.
- R5: A read of global offset 0x00 returns NUM_SRC in bits [11:2], and all of its other bits are 0.
- R6: A shared source n (PRIV_MAX < n < NUM_SRC) is deliverable to core c exactly when `src_i[n]` is 1, its enable is 1, and routing bit c is 1. Masks have no effect on it.
- R7: A private source n (1 <= n <= PRIV_MAX) is deliverable to core c exactly when `src_i[n]` is 1, its enable is 1, and core c's mask bit n is 0. Routing has no effect on it.
- R8: A read of per-core offset 0x44 returns, in bits [9:0], the lowest deliverable index for that core, or 1023 when there is none. Bits [31:10] read 0. The value appears on `bus_rdata` one cycle after the read strobe and reflects the inputs at that clock edge.
- R9: Index 0 is deliverable to core c exactly when `dbell_i[c]` is 1 and core c's mask bit 0 is 0. `src_i[0]` has no effect.
- R10: `irq_o[c]` is 1 exactly when an acknowledge read by core c would return a value other than 1023. It follows register writes on the clock edge that performs them.
- R11: An acknowledge read leaves all enables, masks and routing unchanged, so repeated reads return the same value while the inputs are held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | NUM_SRC | Level-sensitive source lines (bit 0 unused) |
| dbell_i | input | NUM_CPU | Per-core doorbell-pending flags |
| bus_cpu | input | CPU_W | Core whose window is accessed when bus_local=1 |
| bus_local | input | 1 | 1 selects the per-core window, 0 the global window |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 12 | Byte offset within the selected window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| irq_o | output | NUM_CPU | Per-core interrupt outputs |

## Verification
Two things can fall in the same clock edge: a source line or doorbell changing, and an acknowledge read sampling the deliverable set. The bench provokes this by changing `src_i` or `dbell_i` in the same cycle as the read strobe. It also does so while a lower-numbered line is dropping and a higher one is rising. The returned index must match what a model computes from the levels present at that edge, and `irq_o` must agree with it. A register write and a read in the same cycle are also exercised, and the read must not disturb the state the write sets.

// File: rtl/mpic_pkg.sv
package mpic_pkg;

    localparam int unsigned ID_W    = 10;
    localparam logic [ID_W-1:0] NONE_ID = 10'd1023;

    localparam logic [11:0] OFS_CTRL    = 12'h000;
    localparam logic [11:0] OFS_EN_SET  = 12'h030;
    localparam logic [11:0] OFS_EN_CLR  = 12'h034;
    localparam logic [11:0] OFS_ACK     = 12'h044;
    localparam logic [11:0] OFS_MSK_SET = 12'h048;
    localparam logic [11:0] OFS_MSK_CLR = 12'h04C;
    localparam logic [11:0] OFS_ROUTE   = 12'h100;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_EN_SET,
        OP_EN_CLR,
        OP_MSK_SET,
        OP_MSK_CLR,
        OP_ROUTE_WR
    } reg_op_e;

    typedef struct packed {
        reg_op_e         op;
        logic [ID_W-1:0] idx;
        logic [31:0]     data;
    } bus_cmd_t;

    function automatic logic is_route_addr(input logic [11:0] a);
        return (a >= OFS_ROUTE) && (a[1:0] == 2'b00);
    endfunction

    function automatic logic [ID_W-1:0] route_index(input logic [11:0] a);
        logic [11:0] d;
        d = a - OFS_ROUTE;
        return d[11:2];
    endfunction

    function automatic bus_cmd_t decode_cmd(input logic wr, input logic loc,
                                            input logic [11:0] a,
                                            input logic [31:0] wd);
        bus_cmd_t c;
        c.op   = OP_NONE;
        c.idx  = wd[ID_W-1:0];
        c.data = wd;
        if (wr) begin
            if (loc) begin
                if (a == OFS_MSK_SET)      c.op = OP_MSK_SET;
                else if (a == OFS_MSK_CLR) c.op = OP_MSK_CLR;
            end else begin
                if (a == OFS_EN_SET)       c.op = OP_EN_SET;
                else if (a == OFS_EN_CLR)  c.op = OP_EN_CLR;
                else if (is_route_addr(a)) begin
                    c.op  = OP_ROUTE_WR;
                    c.idx = route_index(a);
                end
            end
        end
        return c;
    endfunction

endpackage

// File: rtl/mpic_state.sv
module mpic_state
    import mpic_pkg::*;
#(
    parameter int unsigned NUM_CPU  = 4,
    parameter int unsigned NUM_SRC  = 64,
    parameter int unsigned PRIV_MAX = 28,
    localparam int unsigned CPU_W   = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
    localparam int unsigned SRC_W   = $clog2(NUM_SRC),
    localparam int unsigned PRIV_W  = $clog2(PRIV_MAX + 1)
) (
    input  logic                              clk,
    input  logic                              rst,
    input  bus_cmd_t                          cmd,
    input  logic [CPU_W-1:0]                  cpu_sel,
    output logic [NUM_SRC-1:0]                en,
    output logic [NUM_CPU-1:0][PRIV_MAX:0]    msk,
    output logic [NUM_SRC-1:0][NUM_CPU-1:0]   route
);

    localparam logic [ID_W-1:0] SRC_LIM  = ID_W'(NUM_SRC);
    localparam logic [ID_W-1:0] PRIV_LIM = ID_W'(PRIV_MAX);

    logic src_ok, priv_ok, cpu_ok;
    assign src_ok  = cmd.idx < SRC_LIM;
    assign priv_ok = cmd.idx <= PRIV_LIM;
    assign cpu_ok  = 32'(cpu_sel) < NUM_CPU;

    always_ff @(posedge clk) begin
        if (rst) begin
            en    <= '0;
            msk   <= '1;
            route <= '0;
        end else begin
            case (cmd.op)
                OP_EN_SET:   if (src_ok) en[cmd.idx[SRC_W-1:0]] <= 1'b1;
                OP_EN_CLR:   if (src_ok) en[cmd.idx[SRC_W-1:0]] <= 1'b0;
                OP_MSK_SET:  if (priv_ok && cpu_ok)
                                 msk[cpu_sel][cmd.idx[PRIV_W-1:0]] <= 1'b1;
                OP_MSK_CLR:  if (priv_ok && cpu_ok)
                                 msk[cpu_sel][cmd.idx[PRIV_W-1:0]] <= 1'b0;
                OP_ROUTE_WR: if (src_ok)
                                 route[cmd.idx[SRC_W-1:0]] <= cmd.data[NUM_CPU-1:0];
                default: ;
            endcase
        end
    end

    assert_en_set_R2: assert property (@(posedge clk) disable iff (rst)
        (cmd.op == OP_EN_SET && src_ok) |=> en[$past(cmd.idx[SRC_W-1:0])]);

    assert_en_clr_R2: assert property (@(posedge clk) disable iff (rst)
        (cmd.op == OP_EN_CLR && src_ok) |=> !en[$past(cmd.idx[SRC_W-1:0])]);

    assert_en_bad_idx_R2: assert property (@(posedge clk) disable iff (rst)
        ((cmd.op == OP_EN_SET || cmd.op == OP_EN_CLR) && !src_ok) |=> $stable(en));

    assert_msk_set_R3: assert property (@(posedge clk) disable iff (rst)
        (cmd.op == OP_MSK_SET && priv_ok && cpu_ok)
        |=> msk[$past(cpu_sel)][$past(cmd.idx[PRIV_W-1:0])]);

    assert_msk_bad_idx_R3: assert property (@(posedge clk) disable iff (rst)
        ((cmd.op == OP_MSK_SET || cmd.op == OP_MSK_CLR) && !priv_ok) |=> $stable(msk));

endmodule

// File: rtl/mpic_pick.sv
module mpic_pick
    import mpic_pkg::*;
#(
    parameter int unsigned NUM_CPU  = 4,
    parameter int unsigned NUM_SRC  = 64,
    parameter int unsigned PRIV_MAX = 28
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic [NUM_SRC-1:0]                src_i,
    input  logic [NUM_CPU-1:0]                dbell_i,
    input  logic [NUM_SRC-1:0]                en,
    input  logic [NUM_CPU-1:0][PRIV_MAX:0]    msk,
    input  logic [NUM_SRC-1:0][NUM_CPU-1:0]   route,
    output logic [ID_W-1:0]                   ack_id [NUM_CPU],
    output logic [NUM_CPU-1:0]                irq_o
);

    logic [NUM_CPU-1:0][NUM_SRC-1:0] dlv;

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
        for (genvar n = 0; n < NUM_SRC; n++) begin : g_src
            if (n == 0) begin : g_bell
                assign dlv[c][n] = dbell_i[c] & ~msk[c][0];
            end else if (n <= PRIV_MAX) begin : g_priv
                assign dlv[c][n] = src_i[n] & en[n] & ~msk[c][n];
            end else begin : g_shared
                assign dlv[c][n] = src_i[n] & en[n] & route[n][c];
            end
        end

        always_comb begin
            ack_id[c] = NONE_ID;
            for (int n = NUM_SRC - 1; n >= 0; n--) begin
                if (dlv[c][n]) ack_id[c] = ID_W'(n);
            end
        end

        assign irq_o[c] = |dlv[c];

        assert_irq_ack_R10: assert property (@(posedge clk) disable iff (rst)
            irq_o[c] == (ack_id[c] != NONE_ID));

        assert_ack_range_R8: assert property (@(posedge clk) disable iff (rst)
            (ack_id[c] < ID_W'(NUM_SRC)) || (ack_id[c] == NONE_ID));

        assert_bell_first_R9: assert property (@(posedge clk) disable iff (rst)
            (dbell_i[c] && !msk[c][0]) |-> (ack_id[c] == '0));
    end

endmodule

// File: rtl/mpic_router.sv
module mpic_router
    import mpic_pkg::*;
#(
    parameter int unsigned NUM_CPU  = 4,
    parameter int unsigned NUM_SRC  = 64,
    parameter int unsigned PRIV_MAX = 28,
    localparam int unsigned CPU_W   = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
    localparam int unsigned SRC_W   = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic [NUM_CPU-1:0] dbell_i,
    input  logic [CPU_W-1:0]   bus_cpu,
    input  logic               bus_local,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [11:0]        bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic [NUM_CPU-1:0] irq_o
);

    localparam logic [31:0] CTRL_WORD = 32'(NUM_SRC) << 2;

    bus_cmd_t                            cmd;
    logic [NUM_SRC-1:0]                  en;
    logic [NUM_CPU-1:0][PRIV_MAX:0]      msk;
    logic [NUM_SRC-1:0][NUM_CPU-1:0]     route;
    logic [ID_W-1:0]                     ack_id [NUM_CPU];
    logic [31:0]                         rd_mux;
    logic [ID_W-1:0]                     rt_idx;

    assign cmd = decode_cmd(bus_wr, bus_local, bus_addr, bus_wdata);

    mpic_state #(
        .NUM_CPU (NUM_CPU),
        .NUM_SRC (NUM_SRC),
        .PRIV_MAX(PRIV_MAX)
    ) state_i (
        .clk    (clk),
        .rst    (rst),
        .cmd    (cmd),
        .cpu_sel(bus_cpu),
        .en     (en),
        .msk    (msk),
        .route  (route)
    );

    mpic_pick #(
        .NUM_CPU (NUM_CPU),
        .NUM_SRC (NUM_SRC),
        .PRIV_MAX(PRIV_MAX)
    ) pick_i (
        .clk    (clk),
        .rst    (rst),
        .src_i  (src_i),
        .dbell_i(dbell_i),
        .en     (en),
        .msk    (msk),
        .route  (route),
        .ack_id (ack_id),
        .irq_o  (irq_o)
    );

    assign rt_idx = route_index(bus_addr);

    always_comb begin
        rd_mux = '0;
        if (bus_local) begin
            if (bus_addr == OFS_ACK && 32'(bus_cpu) < NUM_CPU)
                rd_mux = {{(32-ID_W){1'b0}}, ack_id[bus_cpu]};
        end else begin
            if (bus_addr == OFS_CTRL)
                rd_mux = CTRL_WORD;
            else if (is_route_addr(bus_addr) && rt_idx < ID_W'(NUM_SRC))
                rd_mux = 32'(route[rt_idx[SRC_W-1:0]]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst)         bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_mux;
    end

    assert_ctrl_word_R5: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && !bus_local && bus_addr == OFS_CTRL)
        |=> (bus_rdata[11:2] == 10'(NUM_SRC) && bus_rdata[31:12] == '0
             && bus_rdata[1:0] == '0));

    assert_ack_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && !bus_wr && bus_local && bus_addr == OFS_ACK)
        |=> ($stable(en) && $stable(msk) && $stable(route)));

    assert_ack_upper_R8: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_local && bus_addr == OFS_ACK) |=> (bus_rdata[31:10] == '0));

endmodule

// File: tb/mpic_router_tb.sv
module mpic_router_tb_top;

    localparam int NC = 4;
    localparam int NS = 64;
    localparam int PM = 28;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NS-1:0] src_i = '0;
    logic [NC-1:0] dbell_i = '0;
    logic [1:0]    bus_cpu = '0;
    logic          bus_local = 1'b0;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [11:0]   bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NC-1:0] irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    bit       m_en [NS];
    bit       m_msk [NC][PM+1];
    bit [3:0] m_rt [NS];

    always #5 clk = ~clk;

    mpic_router #(.NUM_CPU(NC), .NUM_SRC(NS), .PRIV_MAX(PM)) dut_i (
        .clk(clk), .rst(rst), .src_i(src_i), .dbell_i(dbell_i),
        .bus_cpu(bus_cpu), .bus_local(bus_local), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_o(irq_o)
    );

    function automatic int exp_ack(int c);
        if (dbell_i[c] && !m_msk[c][0]) return 0;
        for (int n = 1; n < NS; n++) begin
            if (src_i[n] && m_en[n] && ((n <= PM) ? !m_msk[c][n] : m_rt[n][c]))
                return n;
        end
        return 1023;
    endfunction

    task automatic chk(string req, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic bus_write(bit loc, int c, int a, int d);
        @(negedge clk);
        bus_local = loc; bus_cpu = 2'(c); bus_addr = 12'(a);
        bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(bit loc, int c, int a, output int d);
        @(negedge clk);
        bus_local = loc; bus_cpu = 2'(c); bus_addr = 12'(a); bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic en_set(int i);
        bus_write(0, 0, 'h30, i);
        if (i < NS) m_en[i] = 1;
    endtask
    task automatic en_clr(int i);
        bus_write(0, 0, 'h34, i);
        if (i < NS) m_en[i] = 0;
    endtask
    task automatic msk_set(int c, int i);
        bus_write(1, c, 'h48, i);
        if (i <= PM) m_msk[c][i] = 1;
    endtask
    task automatic msk_clr(int c, int i);
        bus_write(1, c, 'h4C, i);
        if (i <= PM) m_msk[c][i] = 0;
    endtask
    task automatic rt_wr(int n, int v);
        bus_write(0, 0, 'h100 + 4 * n, v);
        m_rt[n] = 4'(v);
    endtask

    task automatic check_all_cpus(string req);
        int d;
        for (int c = 0; c < NC; c++) begin
            bus_read(1, c, 'h44, d);
            chk(req, d, exp_ack(c));
            chk({req, " irq R10"}, irq_o[c], exp_ack(c) != 1023);
        end
    endtask

    initial begin
        #2000000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int d;
        for (int n = 0; n < NS; n++) begin m_en[n] = 0; m_rt[n] = 0; end
        for (int c = 0; c < NC; c++)
            for (int i = 0; i <= PM; i++) m_msk[c][i] = 1;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state, with every source and doorbell driven high
        src_i = '1; dbell_i = '1;
        @(negedge clk);
        chk("R1 irq", irq_o, 0);
        for (int c = 0; c < NC; c++) begin
            bus_read(1, c, 'h44, d);
            chk("R1 ack", d, 1023);
        end
        for (int n = 0; n < NS; n += 9) begin
            bus_read(0, 0, 'h100 + 4 * n, d);
            chk("R1 route", d, 0);
        end
        src_i = '0; dbell_i = '0;

        // R5: control word
        bus_read(0, 0, 'h00, d);
        chk("R5 ctrl", d, NS << 2);

        // R4: routing readback, upper bits dropped
        for (int n = 0; n < NS; n++) rt_wr(n, 32'hFFFF_FFF0 | ((n * 7 + 3) & 15));
        for (int n = 0; n < NS; n++) begin
            bus_read(0, 0, 'h100 + 4 * n, d);
            chk("R4 route", d, (n * 7 + 3) & 15);
        end

        // R6/R7 sweep: one source at a time
        for (int n = 1; n < NS; n++) begin
            src_i = '0; src_i[n] = 1'b1;
            check_all_cpus(n <= PM ? "R7 disabled" : "R6 disabled");
            en_set(n);
            check_all_cpus(n <= PM ? "R7 masked" : "R6 routed");
            if (n <= PM) begin
                msk_clr(n % NC, n);
                check_all_cpus("R7 one core unmasked, R3 others unaffected");
            end
            en_clr(n);
            check_all_cpus("R2 cleared");
        end
        src_i = '0;

        // R2/R3 out-of-range indices ignored
        src_i = '1;
        en_set(NS); en_set(1023); msk_clr(0, PM + 1); msk_clr(1, 1023);
        check_all_cpus("R2 R3 bad index ignored");

        // R9: doorbell and src_i[0]
        src_i = 64'h1;
        en_set(0);
        dbell_i = 4'b0101;
        check_all_cpus("R9 src0 ignored, bell masked");
        msk_clr(0, 0); msk_clr(1, 0);
        src_i = '1;
        for (int n = 1; n < NS; n++) en_set(n);
        check_all_cpus("R9 bell wins");

        // R11: repeated acknowledge reads
        for (int k = 0; k < 4; k++) begin
            bus_read(1, 2, 'h44, d);
            chk("R11 repeat", d, exp_ack(2));
        end

        // R8 same-edge: level change together with ack read
        dbell_i = '0;
        for (int k = 1; k < 40; k++) begin
            @(negedge clk);
            src_i = '0; src_i[k] = 1'b1; src_i[k + 20] = 1'b1;
            bus_local = 1'b1; bus_cpu = 2'(k % NC); bus_addr = 12'h044; bus_rd = 1'b1;
            @(negedge clk);
            bus_rd = 1'b0;
            chk("R8 same-edge", bus_rdata, exp_ack(k % NC));
        end

        // write and ack read in the same cycle
        @(negedge clk);
        src_i = '0; src_i[40] = 1'b1;
        bus_local = 1'b0; bus_addr = 12'h100 + 4 * 40; bus_wdata = 32'h8;
        bus_wr = 1'b1; bus_rd = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0; m_rt[40] = 4'h8;
        chk("R10 write edge", irq_o, 4'b1000);

        // random mixed sweep
        for (int it = 0; it < 600; it++) begin
            int op, i, c;
            op = $urandom_range(0, 6);
            i  = ($urandom_range(0, 15) == 0) ? $urandom_range(NS, 1023) : $urandom_range(0, NS - 1);
            c  = $urandom_range(0, NC - 1);
            case (op)
                0: en_set(i);
                1: en_clr(i);
                2: msk_set(c, i % 40);
                3: msk_clr(c, i % 40);
                4: if (i < NS) rt_wr(i, $urandom());
                5: begin @(negedge clk); src_i = {$urandom(), $urandom()} & {$urandom(), $urandom()}; end
                default: begin @(negedge clk); dbell_i = 4'($urandom()); end
            endcase
            @(negedge clk);
            for (int k = 0; k < NC; k++)
                chk("R10 random irq", irq_o[k], exp_ack(k) != 1023);
            if (it % 5 == 0) check_all_cpus("R8 random ack");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule